// File: doc/BRIEF.md
# Super I/O Configuration Unlock Port

This block is the configuration-space front end of a legacy I/O controller. The host reaches it through two byte-wide ports: an index port at a base address fixed when the design is elaborated, and a data port at the next address. A byte written to the index port selects a configuration register. A later read or write on the data port then accesses that register.

After reset the port is locked. While it is locked, every byte written to the index port goes to a key matcher instead of selecting a register. When the full four-byte key arrives, the port opens. Once it is open, the host can read the chip identification bytes, select a logical device, and read or write a small window of registers for each device. One of those device windows holds the I/O base of a serial-flash command engine. A global register stores the flash window enables, the flash write enable, the chip-select choice and a suspend flag. The block only stores and returns these values.

Writing the exit value to the control register locks the port again. Host bus decoding and the logic behind the other logical devices are outside this block.

Top module: `sio_cfg_port`

## Requirements
- R1: After a synchronous reset, `cfg_unlocked` is 0 and `io_rdata` is 0xFF.
- R2: While locked, the bytes 0x87, 0x01 and 0x55, then a fourth byte written in order to the index port (address BASE), unlock the port. The fourth byte is 0x55 when BASE is 0x2E and 0xAA when BASE is 0x4E. `cfg_unlocked` rises on the clock edge that takes the fourth byte. With BASE 0x4E, a fourth byte of 0x55 leaves the port locked.
- R3: A byte that does not match the expected key byte sends the matcher back to its first step. If that wrong byte is 0x87, the matcher restarts at the second step, so 0x87 0x01 0x87 0x01 0x55 0x55 unlocks a port at base 0x2E.
- R4: While locked, reads of either port return 0xFF. Data-port writes are ignored, and index-port writes do not change the selected index.
- R5: While unlocked, an index-port write selects a register, and an index-port read returns the selected index. Each read loads `io_rdata` on the clock edge that samples `io_rd`, and `io_rdata` then holds that value.
- R6: Register 0x20 reads 0x87 and register 0x21 reads 0x16. Writes to either register have no effect.
- R7: Register 0x07 is the logical-device number and can be read and written. Registers 0x60 to 0x6F are stored separately for each device number from 0 to 7.
- R8: After reset, with device 7 selected, register 0x64 reads 0x08 and register 0x65 reads 0x20. These are the high and low bytes of the flash engine's I/O base, 0x0820.
- R9: Global register 0x24 resets to 0x00 and stores all 8 bits. Bit 0 is suspend, bits 1 to 3 are flash window enables, bit 4 is the flash write enable and bit 5 is the chip-select choice.
- R10: Writing 0x02 to register 0x02 locks the port on the next edge. Writing any other value there leaves it unlocked.
- R11: While unlocked, registers that are not implemented read 0x00. This includes register 0x02, registers outside 0x07/0x20/0x21/0x24/0x60-0x6F, and the device window when the device number is 8 or above.
- R12: Reads and writes at addresses other than BASE and BASE+1 change no state, and they leave `io_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data, held between reads |
| cfg_unlocked | output | 1 | High while configuration mode is open |

## Verification
Every read result lands in `io_rdata` on the edge that samples the read strobe, so it is due one cycle after the strobe is raised. A key byte or the exit write changes `cfg_unlocked` on the edge that samples the write, so that change is also due one cycle later. The bench drives all strobes on falling edges and samples on the following falling edge, which is exactly one register stage after the rising edge that acts. A behavioural model advances on every rising edge and is compared with both outputs on every falling edge. Directed checks add fixed expected values for each requirement.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0] KEY_B0      = 8'h87;
  localparam logic [7:0] KEY_B1      = 8'h01;
  localparam logic [7:0] KEY_B2      = 8'h55;
  localparam logic [7:0] KEY_END_LO  = 8'h55;  // base 0x2E
  localparam logic [7:0] KEY_END_HI  = 8'hAA;  // base 0x4E
  localparam logic [7:0] REG_CTRL    = 8'h02;
  localparam logic [7:0] REG_LDN     = 8'h07;
  localparam logic [7:0] REG_ID_HI   = 8'h20;
  localparam logic [7:0] REG_ID_LO   = 8'h21;
  localparam logic [7:0] REG_GLOBAL  = 8'h24;
  localparam logic [7:0] EXIT_CODE   = 8'h02;
  localparam logic [7:0] LOCKED_BYTE = 8'hFF;

  typedef enum logic [1:0] {KS_0, KS_1, KS_2, KS_3} key_step_e;

  function automatic logic [7:0] final_key(input logic [15:0] base);
    return (base == 16'h004E) ? KEY_END_HI : KEY_END_LO;
  endfunction
endpackage

// File: rtl/sio_key_seq.sv
module sio_key_seq
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] LAST_KEY = 8'h55
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic [7:0] key_byte,
  input  logic       lock_req,
  output logic       unlocked
);
  key_step_e  step;
  logic [7:0] want;

  always_comb begin
    case (step)
      KS_0:    want = KEY_B0;
      KS_1:    want = KEY_B1;
      KS_2:    want = KEY_B2;
      default: want = LAST_KEY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step     <= KS_0;
      unlocked <= 1'b0;
    end else if (unlocked) begin
      if (lock_req) unlocked <= 1'b0;
    end else if (key_wr) begin
      if (key_byte == want) begin
        if (step == KS_3) begin
          unlocked <= 1'b1;
          step     <= KS_0;
        end else begin
          step <= key_step_e'(step + 2'd1);
        end
      end else begin
        step <= (key_byte == KEY_B0) ? KS_1 : KS_0;
      end
    end
  end

  // R3
  key_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (!unlocked && key_wr && key_byte == KEY_B0) |=> (step == KS_1));

  // R2
  key_open_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(key_wr && key_byte == LAST_KEY && step == KS_3));
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
  import sio_cfg_pkg::*;
#(
  parameter int          NUM_LDN    = 8,
  parameter int          DEV_CNT    = 16,
  parameter logic [7:0]  DEV_LO     = 8'h60,
  parameter int          FLASH_LDN  = 7,
  parameter logic [7:0]  FLASH_REG  = 8'h64,
  parameter logic [15:0] FLASH_BASE = 16'h0820,
  parameter logic [15:0] CHIP_ID    = 16'h8716,
  parameter logic [7:0]  GLOBAL_RST = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rd_val,
  output logic       lock_req
);
  localparam int LDN_W     = (NUM_LDN > 1) ? $clog2(NUM_LDN) : 1;
  localparam int OFF_W     = $clog2(DEV_CNT);
  localparam int IDX_W     = LDN_W + OFF_W;
  localparam int ENTRIES   = NUM_LDN * DEV_CNT;
  localparam int FLASH_IDX = FLASH_LDN * DEV_CNT + int'(FLASH_REG - DEV_LO);

  logic [7:0]       ldn_q;
  logic [7:0]       glob_q;
  logic [7:0]       dev_mem [ENTRIES];
  logic             in_win;
  logic             ldn_ok;
  logic [IDX_W-1:0] dev_idx;

  // DEV_LO is aligned to DEV_CNT, so the low address bits are the offset.
  assign in_win   = (addr[7:OFF_W] == DEV_LO[7:OFF_W]);
  assign ldn_ok   = (ldn_q < 8'(NUM_LDN));
  assign dev_idx  = {ldn_q[LDN_W-1:0], addr[OFF_W-1:0]};
  assign lock_req = wr_en && (addr == REG_CTRL) && (wdata == EXIT_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ldn_q  <= 8'h00;
      glob_q <= GLOBAL_RST;
      for (int i = 0; i < ENTRIES; i++) begin
        dev_mem[i] <= (i == FLASH_IDX)     ? FLASH_BASE[15:8] :
                      (i == FLASH_IDX + 1) ? FLASH_BASE[7:0]  : 8'h00;
      end
    end else if (wr_en) begin
      if (addr == REG_LDN)    ldn_q  <= wdata;
      if (addr == REG_GLOBAL) glob_q <= wdata;
      if (in_win && ldn_ok)   dev_mem[dev_idx] <= wdata;
    end
  end

  always_comb begin
    case (addr)
      REG_LDN:    rd_val = ldn_q;
      REG_ID_HI:  rd_val = CHIP_ID[15:8];
      REG_ID_LO:  rd_val = CHIP_ID[7:0];
      REG_GLOBAL: rd_val = glob_q;
      default:    rd_val = (in_win && ldn_ok) ? dev_mem[dev_idx] : 8'h00;
    endcase
  end

  // R7
  ldn_store_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == REG_LDN) |=> (ldn_q == $past(wdata)));

  // R9
  glob_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == REG_GLOBAL) |=> $stable(glob_q));
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter logic [15:0] BASE       = 16'h002E,
  parameter int          NUM_LDN    = 8,
  parameter int          DEV_CNT    = 16,
  parameter logic [15:0] FLASH_BASE = 16'h0820,
  parameter logic [15:0] CHIP_ID    = 16'h8716
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              cfg_unlocked
);
  localparam logic [ADDR_W-1:0] IDX_ADDR = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] DAT_ADDR = ADDR_W'(BASE) + ADDR_W'(1);
  localparam logic [7:0]        LAST_KEY = final_key(BASE);

  logic       idx_hit, dat_hit, port_rd, reg_wr, lock_req;
  logic [7:0] idx_q, rd_val;

  assign idx_hit = (io_addr == IDX_ADDR);
  assign dat_hit = (io_addr == DAT_ADDR);
  assign port_rd = io_rd && (idx_hit || dat_hit);
  assign reg_wr  = io_wr && dat_hit && cfg_unlocked;

  sio_key_seq #(.LAST_KEY(LAST_KEY)) i_key (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (io_wr && idx_hit),
    .key_byte (io_wdata),
    .lock_req (lock_req),
    .unlocked (cfg_unlocked)
  );

  sio_cfg_regs #(
    .NUM_LDN    (NUM_LDN),
    .DEV_CNT    (DEV_CNT),
    .FLASH_BASE (FLASH_BASE),
    .CHIP_ID    (CHIP_ID)
  ) i_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (reg_wr),
    .addr     (idx_q),
    .wdata    (io_wdata),
    .rd_val   (rd_val),
    .lock_req (lock_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= 8'h00;
      io_rdata <= LOCKED_BYTE;
    end else begin
      if (io_wr && idx_hit && cfg_unlocked) idx_q <= io_wdata;
      if (port_rd) begin
        if (!cfg_unlocked) io_rdata <= LOCKED_BYTE;
        else if (idx_hit)  io_rdata <= idx_q;
        else               io_rdata <= rd_val;
      end
    end
  end

  // R4
  locked_read_chk: assert property (@(posedge clk) disable iff (rst)
    (port_rd && !cfg_unlocked) |=> (io_rdata == LOCKED_BYTE));

  // R10
  exit_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && idx_q == REG_CTRL && io_wdata == EXIT_CODE) |=> !cfg_unlocked);

  // R6
  chip_id_chk: assert property (@(posedge clk) disable iff (rst)
    (io_rd && dat_hit && cfg_unlocked && idx_q == REG_ID_HI) |=> (io_rdata == CHIP_ID[15:8]));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !port_rd |=> $stable(io_rdata));
endmodule

// File: tb/test_sio_cfg_port.sv
module test_sio_cfg_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = 16'h0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h0;
  logic [7:0]  io_rdata;
  logic        cfg_unlocked;

  logic [15:0] b_addr = 16'h0;
  logic        b_wr = 1'b0, b_rd = 1'b0;
  logic [7:0]  b_wdata = 8'h0;
  logic [7:0]  b_rdata;
  logic        b_unlocked;

  int total = 0, bad = 0, cycles = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  sio_cfg_port #(.BASE(16'h002E)) i_sio_cfg_port (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_unlocked(cfg_unlocked));

  sio_cfg_port #(.BASE(16'h004E)) i_sio_cfg_port_b (
    .clk(clk), .rst(rst), .io_addr(b_addr), .io_wr(b_wr), .io_rd(b_rd),
    .io_wdata(b_wdata), .io_rdata(b_rdata), .cfg_unlocked(b_unlocked));

  // behavioural reference for the 0x2E instance
  int         m_step;
  bit         m_unl;
  logic [7:0] m_idx, m_ldn, m_glob, m_rdata;
  logic [7:0] m_dev [8][16];
  logic [7:0] m_keys [4] = '{8'h87, 8'h01, 8'h55, 8'h55};

  function automatic logic [7:0] m_lookup(input logic [7:0] r);
    if (r == 8'h07) return m_ldn;
    if (r == 8'h20) return 8'h87;
    if (r == 8'h21) return 8'h16;
    if (r == 8'h24) return m_glob;
    if (r >= 8'h60 && r <= 8'h6F && m_ldn < 8) return m_dev[m_ldn][r - 8'h60];
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_step = 0; m_unl = 0; m_idx = 0; m_ldn = 0; m_glob = 0; m_rdata = 8'hFF;
      foreach (m_dev[d, k]) m_dev[d][k] = 8'h00;
      m_dev[7][4] = 8'h08; m_dev[7][5] = 8'h20;
    end else begin
      if (io_rd && (io_addr == 16'h2E || io_addr == 16'h2F))
        m_rdata = !m_unl ? 8'hFF : (io_addr == 16'h2E) ? m_idx : m_lookup(m_idx);
      if (io_wr && io_addr == 16'h2E) begin
        if (m_unl) m_idx = io_wdata;
        else if (io_wdata == m_keys[m_step]) begin
          m_step++;
          if (m_step == 4) begin m_unl = 1; m_step = 0; end
        end else m_step = (io_wdata == 8'h87) ? 1 : 0;
      end else if (io_wr && io_addr == 16'h2F && m_unl) begin
        if (m_idx == 8'h02 && io_wdata == 8'h02) m_unl = 0;
        else if (m_idx == 8'h07) m_ldn = io_wdata;
        else if (m_idx == 8'h24) m_glob = io_wdata;
        else if (m_idx >= 8'h60 && m_idx <= 8'h6F && m_ldn < 8) m_dev[m_ldn][m_idx - 8'h60] = io_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      total++;
      if (io_rdata !== m_rdata || cfg_unlocked !== m_unl) begin
        bad++;
        $display("FAIL %s model: rdata=%h unl=%b expected rdata=%h unl=%b",
                 cur_req, io_rdata, cfg_unlocked, m_rdata, m_unl);
      end
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0; v = io_rdata;
  endtask

  task automatic rdreg(input logic [7:0] r, output logic [7:0] v);
    wr(16'h2E, r);
    rd(16'h2F, v);
  endtask

  task automatic wr_b(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); b_addr = a; b_wdata = d; b_wr = 1'b1;
    @(negedge clk); b_wr = 1'b0;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {7'd0, cfg_unlocked}, 8'h00);
    check("R1", io_rdata, 8'hFF);

    cur_req = "R4";
    rd(16'h2F, v); check("R4", v, 8'hFF);
    rd(16'h2E, v); check("R4", v, 8'hFF);
    wr(16'h2F, 8'h02);

    cur_req = "R3";
    wr(16'h2E, 8'h87); wr(16'h2E, 8'h01); wr(16'h2E, 8'h00);
    wr(16'h2E, 8'h55); wr(16'h2E, 8'h55);
    check("R3", {7'd0, cfg_unlocked}, 8'h00);
    wr(16'h2E, 8'h87); wr(16'h2E, 8'h01); wr(16'h2E, 8'h87);
    wr(16'h2E, 8'h01); wr(16'h2E, 8'h55);
    check("R2", {7'd0, cfg_unlocked}, 8'h00);
    wr(16'h2E, 8'h55);
    check("R3", {7'd0, cfg_unlocked}, 8'h01);

    cur_req = "R5";
    wr(16'h2E, 8'h20); rd(16'h2E, v); check("R5", v, 8'h20);
    cur_req = "R6";
    rd(16'h2F, v); check("R6", v, 8'h87);
    wr(16'h2F, 8'h5C); rd(16'h2F, v); check("R6", v, 8'h87);
    rdreg(8'h21, v); check("R6", v, 8'h16);
    wr(16'h2F, 8'hAB); rd(16'h2F, v); check("R6", v, 8'h16);

    cur_req = "R8";
    wr(16'h2E, 8'h07); wr(16'h2F, 8'h07);
    rdreg(8'h64, v); check("R8", v, 8'h08);
    rdreg(8'h65, v); check("R8", v, 8'h20);

    cur_req = "R7";
    wr(16'h2E, 8'h07); wr(16'h2F, 8'h03);
    rdreg(8'h07, v); check("R7", v, 8'h03);
    wr(16'h2E, 8'h64); wr(16'h2F, 8'h5A);
    rd(16'h2F, v); check("R7", v, 8'h5A);
    wr(16'h2E, 8'h07); wr(16'h2F, 8'h07);
    rdreg(8'h64, v); check("R7", v, 8'h08);

    cur_req = "R11";
    rdreg(8'h30, v); check("R11", v, 8'h00);
    rdreg(8'h02, v); check("R11", v, 8'h00);
    wr(16'h2E, 8'h07); wr(16'h2F, 8'h09);
    wr(16'h2E, 8'h64); wr(16'h2F, 8'h77);
    rd(16'h2F, v); check("R11", v, 8'h00);

    cur_req = "R9";
    rdreg(8'h24, v); check("R9", v, 8'h00);
    wr(16'h2F, 8'hBF); rd(16'h2F, v); check("R9", v, 8'hBF);

    cur_req = "R12";
    wr(16'h2C, 8'h24); wr(16'h2D, 8'h11); wr(16'h4F, 8'h22);
    rd(16'h30, v); check("R12", v, 8'hBF);
    rd(16'h2F, v); check("R12", v, 8'hBF);
    rd(16'h2E, v); check("R12", v, 8'h24);

    cur_req = "R10";
    wr(16'h2E, 8'h02); wr(16'h2F, 8'h01);
    check("R10", {7'd0, cfg_unlocked}, 8'h01);
    wr(16'h2F, 8'h02);
    check("R10", {7'd0, cfg_unlocked}, 8'h00);

    cur_req = "R4";
    rd(16'h2F, v); check("R4", v, 8'hFF);
    wr(16'h2E, 8'h24); wr(16'h2F, 8'h66);
    cur_req = "R2";
    wr(16'h2E, 8'h87); wr(16'h2E, 8'h01); wr(16'h2E, 8'h55); wr(16'h2E, 8'h55);
    check("R2", {7'd0, cfg_unlocked}, 8'h01);
    cur_req = "R4";
    rd(16'h2E, v); check("R4", v, 8'h02);
    rdreg(8'h24, v); check("R4", v, 8'hBF);

    cur_req = "R2";
    wr_b(16'h4E, 8'h87); wr_b(16'h4E, 8'h01); wr_b(16'h4E, 8'h55); wr_b(16'h4E, 8'h55);
    check("R2", {7'd0, b_unlocked}, 8'h00);
    wr_b(16'h4E, 8'h87); wr_b(16'h4E, 8'h01); wr_b(16'h4E, 8'h55); wr_b(16'h4E, 8'hAA);
    check("R2", {7'd0, b_unlocked}, 8'h01);
    wr_b(16'h4E, 8'h20);
    @(negedge clk); b_addr = 16'h4F; b_rd = 1'b1;
    @(negedge clk); b_rd = 1'b0;
    check("R2", b_rdata, 8'h87);

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        total++; bad++;
        $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule